// File: doc/BRIEF.md
# Multi-channel DMA interrupt aggregator

This block gathers one-cycle completion pulses from a bank of DMA channel pairs and combines them into a single level-sensitive interrupt line. Each instance of the channel bank has a receive side and a transmit side. The receive side of instance k drives channel 2k and the transmit side drives channel 2k+1, so receive channels always have even numbers and transmit channels always have odd numbers. Every channel owns one bit, with the same bit position, in each of the three registers.

Software reaches three 32-bit registers through a simple register port. The status register latches completions, and a channel's bit is cleared by writing a 1 to it. The enable register holds the per-channel mask. The pending register is read-only and gives status ANDed with enable. The interrupt output is high whenever any pending bit is set. A typical handler reads pending, writes the same value back to status to acknowledge it, and reprograms enable.

Top module: `dma_irq_aggregator`

## Requirements
- R1: While reset is held and straight after it, status and enable are zero, the interrupt output is low and the read data is zero.
- R2: A pulse on rx_done_i[k] sets status bit 2k and a pulse on tx_done_i[k] sets status bit 2k+1. The bit is set from the clock edge that samples the pulse and stays set until it is cleared.
- R3: A write to offset 0x080000 clears every status bit whose write-data bit is 1 and leaves the other bits alone. Writing 0xFFFFFFFF clears all status bits.
- R4: When a completion pulse and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R5: A write to offset 0x080008 loads the enable register from the low write-data bits. Reads return it with every bit at or above the channel count at zero.
- R6: A read of offset 0x080004 returns status AND enable. Writes to that offset change neither status nor enable.
- R7: irq_o is high exactly when status AND enable is nonzero, so an enable of zero holds it low.
- R8: Reads of any offset other than the three above return zero, and writes to such offsets change no register.
- R9: Read data is registered. It appears the cycle after reg_rd_i, shows register contents from before any write in the same cycle, and holds while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done_i | input | NUM_INST | Receive completion pulses, one per channel-pair instance |
| tx_done_i | input | NUM_INST | Transmit completion pulses, one per channel-pair instance |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt, high while any enabled status bit is set |

## Verification
Status and enable change at the clock edge that samples a pulse or a write. irq_o follows that same edge with no extra register, and read data comes one edge after the read strobe. The bench drives every stimulus just after a falling edge and samples every result at the next falling edge, so each check lands one register stage after its stimulus. Same-cycle cases are driven on a single strobe: set against clear on one bit, and a read together with a write to the same register. Their expected values come from the state before that edge.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    // Which register an access selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_PEND = 2'd2,
        SEL_EN   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_chan_map.sv
module irq_chan_map #(
    parameter int NUM_INST = 16,
    localparam int NUM_CH  = 2 * NUM_INST
) (
    input  logic [NUM_INST-1:0] rx_done_i,
    input  logic [NUM_INST-1:0] tx_done_i,
    output logic [NUM_CH-1:0]   done_o
);

    // Instance k: receive side -> channel 2k, transmit side -> channel 2k+1
    for (genvar k = 0; k < NUM_INST; k++) begin : g_pair
        assign done_o[2*k]     = rx_done_i[k];
        assign done_o[2*k + 1] = tx_done_i[k];
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              clr_en_i,
    input  logic [NUM_CH-1:0] clr_mask_i,
    output logic [NUM_CH-1:0] status_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] status;
    } bank_t;

    bank_t             bank_d, bank_q;
    logic [NUM_CH-1:0] clr_vec;

    always_comb begin
        bank_d  = bank_q;
        clr_vec = clr_en_i ? clr_mask_i : '0;
        // a new completion outranks an acknowledge on the same bit
        bank_d.status = (bank_q.status & ~clr_vec) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign status_o = bank_q.status;

    // R2 / R4: a sampled pulse always leaves its bit set
    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R2: no bit rises without a pulse
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(set_i)) == '0));

    // R3: cleared bits without a concurrent pulse are low afterwards
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((status_o & $past(clr_mask_i) & ~$past(set_i)) == '0));

    // R3: bits outside the clear mask never fall
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status_o & $past(status_o) & ~($past(clr_en_i) ? $past(clr_mask_i) : '0)) == '0));

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import dma_irq_pkg::*;
#(
    parameter int              NUM_CH   = 32,
    parameter int              ADDR_W   = 20,
    parameter int              DATA_W   = 32,
    parameter logic [ADDR_W-1:0] STAT_OFS = 20'h80000,
    parameter logic [ADDR_W-1:0] PEND_OFS = 20'h80004,
    parameter logic [ADDR_W-1:0] EN_OFS   = 20'h80008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NUM_CH-1:0] status_i,
    input  logic [NUM_CH-1:0] pend_i,
    output logic              clr_en_o,
    output logic [NUM_CH-1:0] clr_mask_o,
    output logic [NUM_CH-1:0] enable_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] enable;
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t             port_d, port_q;
    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_word;

    // Upper write-data bits have no channel behind them
    if (NUM_CH < DATA_W) begin : g_hi
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_CH];
    end

    always_comb begin
        if (addr_i == STAT_OFS) begin
            sel = SEL_STAT;
        end else if (addr_i == PEND_OFS) begin
            sel = SEL_PEND;
        end else if (addr_i == EN_OFS) begin
            sel = SEL_EN;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_STAT: rd_word[NUM_CH-1:0] = status_i;
            SEL_PEND: rd_word[NUM_CH-1:0] = pend_i;
            SEL_EN:   rd_word[NUM_CH-1:0] = port_q.enable;
            default:  rd_word = '0;
        endcase
    end

    always_comb begin
        port_d = port_q;
        if (wr_i && (sel == SEL_EN)) begin
            port_d.enable = wdata_i[NUM_CH-1:0];
        end
        if (rd_i) begin
            port_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign clr_en_o   = wr_i && (sel == SEL_STAT);
    assign clr_mask_o = wdata_i[NUM_CH-1:0];
    assign enable_o   = port_q.enable;
    assign rdata_o    = port_q.rdata;

    // R5: a write to the enable offset loads the mask
    p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == EN_OFS) |=> (enable_o == $past(wdata_i[NUM_CH-1:0])));

    // R6 / R8: enable only moves on a write to its own offset
    p_enable_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == EN_OFS) |=> $stable(enable_o));

    // R8: unmapped reads return zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i != STAT_OFS && addr_i != PEND_OFS && addr_i != EN_OFS)
        |=> (rdata_o == '0));

    // R9: read data holds without a read
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator #(
    parameter int NUM_INST = 16,
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 32,
    parameter logic [ADDR_W-1:0] STAT_OFS = 20'h80000,
    parameter logic [ADDR_W-1:0] PEND_OFS = 20'h80004,
    parameter logic [ADDR_W-1:0] EN_OFS   = 20'h80008
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INST-1:0] rx_done_i,
    input  logic [NUM_INST-1:0] tx_done_i,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o
);

    localparam int NUM_CH = 2 * NUM_INST;

    logic [NUM_CH-1:0] done_vec;
    logic [NUM_CH-1:0] status_vec;
    logic [NUM_CH-1:0] enable_vec;
    logic [NUM_CH-1:0] pend_vec;
    logic              clr_en;
    logic [NUM_CH-1:0] clr_mask;

    irq_chan_map #(
        .NUM_INST (NUM_INST)
    ) u_map (
        .rx_done_i (rx_done_i),
        .tx_done_i (tx_done_i),
        .done_o    (done_vec)
    );

    irq_status_bank #(
        .NUM_CH (NUM_CH)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (done_vec),
        .clr_en_i   (clr_en),
        .clr_mask_i (clr_mask),
        .status_o   (status_vec)
    );

    irq_reg_port #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .STAT_OFS (STAT_OFS),
        .PEND_OFS (PEND_OFS),
        .EN_OFS   (EN_OFS)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .status_i   (status_vec),
        .pend_i     (pend_vec),
        .clr_en_o   (clr_en),
        .clr_mask_o (clr_mask),
        .enable_o   (enable_vec),
        .rdata_o    (reg_rdata_o)
    );

    assign pend_vec = status_vec & enable_vec;
    assign irq_o    = |pend_vec;

    // R7: a raised line needs at least one enabled channel
    p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (enable_vec != '0));

    // R7: the line is low while no completion is latched
    p_irq_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_vec == '0) |-> !irq_o);

    // R2: a pulse on an enabled channel raises the line on the next cycle
    p_irq_after_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_vec & enable_vec) != '0) && !(reg_wr_i && reg_addr_i == EN_OFS) |=> irq_o);

endmodule

// File: tb/dma_irq_aggregator_bench.sv
module dma_irq_aggregator_bench;

    localparam int NI  = 2;
    localparam int NCH = 2 * NI;
    localparam logic [19:0] A_STAT = 20'h80000;
    localparam logic [19:0] A_PEND = 20'h80004;
    localparam logic [19:0] A_EN   = 20'h80008;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] rx_done = '0;
    logic [NI-1:0] tx_done = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [19:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [NCH-1:0] m_stat = '0;
    logic [NCH-1:0] m_en = '0;

    always #5 clk = ~clk;

    dma_irq_aggregator #(.NUM_INST(NI)) u_dma_irq_aggregator (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_done_i   (rx_done),
        .tx_done_i   (tx_done),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // even channel = receive side, odd channel = transmit side
    function automatic logic [NCH-1:0] weave(input logic [NI-1:0] rx, input logic [NI-1:0] tx);
        logic [NCH-1:0] v;
        for (int k = 0; k < NI; k++) begin
            v[2*k]   = rx[k];
            v[2*k+1] = tx[k];
        end
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [19:0] a);
        logic [31:0] v;
        v = '0;
        if (a == A_STAT) v[NCH-1:0] = m_stat;
        else if (a == A_PEND) v[NCH-1:0] = m_stat & m_en;
        else if (a == A_EN) v[NCH-1:0] = m_en;
        return v;
    endfunction

    // one bus cycle: drive after a falling edge, sample at the next one
    task automatic cyc(input bit rd, input bit wr, input logic [19:0] a, input logic [31:0] wd,
                       input logic [NI-1:0] rx, input logic [NI-1:0] tx, output logic [31:0] got);
        logic [NCH-1:0] clr;
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        rx_done = rx; tx_done = tx;
        @(negedge clk);
        got = reg_rdata;
        reg_rd = 1'b0; reg_wr = 1'b0; rx_done = '0; tx_done = '0;
        clr = (wr && a == A_STAT) ? wd[NCH-1:0] : '0;
        m_stat = (m_stat & ~clr) | weave(rx, tx);
        if (wr && a == A_EN) m_en = wd[NCH-1:0];
    endtask

    task automatic rd_chk(input string req, input logic [19:0] a);
        logic [31:0] e, g;
        e = model_read(a);
        cyc(1, 0, a, '0, '0, '0, g);
        chk(req, g, e);
    endtask

    task automatic wr_only(input logic [19:0] a, input logic [31:0] d);
        logic [31:0] g;
        cyc(0, 1, a, d, '0, '0, g);
    endtask

    task automatic pulse(input logic [NI-1:0] rx, input logic [NI-1:0] tx);
        logic [31:0] g;
        cyc(0, 0, A_STAT, '0, rx, tx, g);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] g, e;
        repeat (3) @(negedge clk);
        chk("R1 rdata in reset", reg_rdata, 32'h0);
        chk("R1 irq in reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 status after reset", A_STAT);
        rd_chk("R1 enable after reset", A_EN);
        rd_chk("R1 pending after reset", A_PEND);

        // R2 / R3: every single channel, set then clear
        for (int c = 0; c < NCH; c++) begin
            logic [NCH-1:0] one;
            one = NCH'(1) << c;
            pulse(one[NI-1:0] == '0 ? '0 : '0, '0);
            cyc(0, 0, A_STAT, '0,
                (c % 2 == 0) ? NI'(1) << (c / 2) : '0,
                (c % 2 == 1) ? NI'(1) << (c / 2) : '0, g);
            chk("R2 bit position", {28'h0, m_stat}, {28'h0, one});
            rd_chk("R2 status read", A_STAT);
            wr_only(A_STAT, 32'(one));
            rd_chk("R3 single clear", A_STAT);
        end

        // R3: partial clear keeps other bits, all-ones clears everything
        pulse('1, '1);
        wr_only(A_STAT, 32'h5);
        rd_chk("R3 partial clear", A_STAT);
        chk("R3 partial value", {28'h0, m_stat}, 32'hA);
        wr_only(A_STAT, 32'hFFFF_FFFF);
        rd_chk("R3 clear all", A_STAT);

        // R4: set and clear on the same bit in the same cycle
        pulse(2'b11, 2'b00);
        cyc(0, 1, A_STAT, 32'h5, 2'b01, 2'b00, g);
        rd_chk("R4 set wins", A_STAT);
        chk("R4 value", {28'h0, m_stat}, 32'h1);
        wr_only(A_STAT, 32'hFFFF_FFFF);

        // R5: upper enable bits read zero
        wr_only(A_EN, 32'hFFFF_FFFF);
        rd_chk("R5 enable width", A_EN);
        chk("R5 value", {28'h0, m_en}, 32'hF);

        // R6: writes to pending have no effect
        pulse(2'b01, 2'b10);
        wr_only(A_PEND, 32'hFFFF_FFFF);
        rd_chk("R6 status after pending write", A_STAT);
        rd_chk("R6 enable after pending write", A_EN);

        // R8: unmapped offsets
        wr_only(20'h8000C, 32'hFFFF_FFFF);
        wr_only(20'h00000, 32'hFFFF_FFFF);
        rd_chk("R8 unmapped 0x8000C", 20'h8000C);
        rd_chk("R8 unmapped 0x00000", 20'h00000);
        rd_chk("R8 unmapped 0x80002", 20'h80002);
        rd_chk("R8 status kept", A_STAT);
        rd_chk("R8 enable kept", A_EN);

        // R9: read with same-cycle write returns old contents, then holds
        e = model_read(A_EN);
        cyc(1, 1, A_EN, 32'h3, '0, '0, g);
        chk("R9 read before write", g, e);
        cyc(0, 0, A_STAT, '0, '0, '0, g);
        chk("R9 rdata holds", g, e);
        rd_chk("R9 new enable visible", A_EN);

        // R5 / R6 / R7: sweep every enable mask against every status pattern
        for (int en = 0; en < (1 << NCH); en++) begin
            for (int st = 0; st < (1 << NCH); st++) begin
                logic [NCH-1:0] sv;
                sv = NCH'(st);
                wr_only(A_EN, 32'(en));
                wr_only(A_STAT, 32'hFFFF_FFFF);
                chk("R7 irq low after clear", {31'h0, irq}, 32'h0);
                cyc(0, 0, A_STAT, '0, {sv[2], sv[0]}, {sv[3], sv[1]}, g);
                chk("R7 irq level", {31'h0, irq}, {31'h0, |(NCH'(st) & NCH'(en))});
                rd_chk("R6 pending value", A_PEND);
                rd_chk("R5 enable readback", A_EN);
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule